// File: doc/BRIEF.md
# Two-Stage Pipelined Modular Adder

This block adds two residues modulo a run-time modulus and returns the reduced sum. It is meant to sit beside a modular multiplier inside a prime-field arithmetic core, where a new addition can be issued on every clock cycle and the result is collected a fixed two cycles later.

Two carry chains run side by side. One forms the plain sum. The other forms the sum minus the modulus, using a carry-save row that folds in the complemented modulus. Both chains are split at mid-width by a pipeline register, so the longest path is about half a ripple chain. In the second stage the top bit of the extended reduced chain selects which sum is returned. Both operands must already be reduced, which means each is strictly below the modulus.

Top module: `pipe_mod_adder`

## Requirements
- R1: When out_valid is high, out_res equals X+Y−M if X+Y ≥ M and X+Y otherwise, where X, Y and M were the in_x, in_y and in_mod sampled with the matching in_valid.
- R2: Operands sampled with in_valid high at a rising clock edge produce out_valid high after the following rising edge, so the latency is two edges.
- R3: A new operand pair may be presented on every cycle. Back-to-back operations with different moduli give independent, correct results.
- R4: out_valid is low after reset, and it is low two edges after any cycle in which in_valid was low.
- R5: For reduced operands, every valid result is strictly below the modulus of its operation.
- R6: When X+Y equals M exactly, the result is zero.
- R7: When X+Y reaches or exceeds 2^WIDTH, the reduced value is the one selected, and the result is still correct.
- R8: A carry produced in the lower half of either chain is carried correctly into the upper half in the next stage, for example 0x00FF + 0x0001 gives 0x0100 with a 16-bit width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair and modulus are valid this cycle |
| in_x | input | WIDTH | First addend, below in_mod |
| in_y | input | WIDTH | Second addend, below in_mod |
| in_mod | input | WIDTH | Modulus, at least 2 |
| out_valid | output | 1 | out_res holds a result |
| out_res | output | WIDTH | Reduced sum |

## Verification
The assertions assume that every valid operation carries operands strictly below a modulus of at least two. Under that assumption the extended reduced chain never carries beyond its top bit, and an overflow of the plain sum always forces the reduced path. The random stimulus first draws a modulus from the range 2 to 2^WIDTH−1 and then draws each operand as a remainder modulo that modulus. The directed cases are chosen by hand so that they stay within the same bounds.

// File: rtl/modadd_pkg.sv
package modadd_pkg;

  // Single-bit full-adder sum
  function automatic logic fa_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  // Single-bit full-adder carry (majority)
  function automatic logic fa_carry(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/rca_seg.sv
module rca_seg #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         cout
);
  import modadd_pkg::*;

  logic [W:0] cc;
  assign cc[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign s[i]    = fa_sum(a[i], b[i], cc[i]);
    assign cc[i+1] = fa_carry(a[i], b[i], cc[i]);
  end

  assign cout = cc[W];
endmodule

// File: rtl/csa_row.sv
module csa_row #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] s,
  output logic [W-1:0] cy   // cy[i] has weight 2^(i+1)
);
  import modadd_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_col
    assign s[i]  = fa_sum(a[i], b[i], c[i]);
    assign cy[i] = fa_carry(a[i], b[i], c[i]);
  end
endmodule

// File: rtl/pipe_mod_adder.sv
module pipe_mod_adder #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_x,
  input  logic [WIDTH-1:0] in_y,
  input  logic [WIDTH-1:0] in_mod,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_res
);
  localparam int LO_W = WIDTH / 2;
  localparam int HI_W = WIDTH - LO_W;

  // Final selection: reduced value when its extended top bit is set
  function automatic logic [WIDTH-1:0] pick_result(
    input logic             nonneg,
    input logic [WIDTH-1:0] plain,
    input logic [WIDTH-1:0] reduced
  );
    return nonneg ? reduced : plain;
  endfunction

  // ---------------- stage 1: lower halves + carry-save row ----------------
  logic [WIDTH-1:0] csa_s, csa_cy;
  logic [LO_W-1:0]  sum_lo, dif_lo;
  logic             sum_lo_c, dif_lo_c;

  // x + y + ~m ; the "+1" of the complement fills the empty weight-1 slot
  csa_row #(.W(WIDTH)) u_csa (
    .a (in_x), .b (in_y), .c (~in_mod), .s (csa_s), .cy (csa_cy)
  );

  rca_seg #(.W(LO_W)) u_sum_lo (
    .a (in_x[LO_W-1:0]), .b (in_y[LO_W-1:0]), .cin (1'b0),
    .s (sum_lo), .cout (sum_lo_c)
  );

  rca_seg #(.W(LO_W)) u_dif_lo (
    .a (csa_s[LO_W-1:0]), .b ({csa_cy[LO_W-2:0], 1'b1}), .cin (1'b0),
    .s (dif_lo), .cout (dif_lo_c)
  );

  logic            v1_q;
  logic [LO_W-1:0] sum_lo_q, dif_lo_q;
  logic            sum_c_q, dif_c_q;
  logic [HI_W-1:0] x_hi_q, y_hi_q, s_hi_q;
  logic [HI_W:0]   cy_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q     <= 1'b0;
      sum_lo_q <= '0;
      dif_lo_q <= '0;
      sum_c_q  <= 1'b0;
      dif_c_q  <= 1'b0;
      x_hi_q   <= '0;
      y_hi_q   <= '0;
      s_hi_q   <= '0;
      cy_hi_q  <= '0;
    end else begin
      v1_q     <= in_valid;
      sum_lo_q <= sum_lo;
      dif_lo_q <= dif_lo;
      sum_c_q  <= sum_lo_c;
      dif_c_q  <= dif_lo_c;
      x_hi_q   <= in_x[WIDTH-1:LO_W];
      y_hi_q   <= in_y[WIDTH-1:LO_W];
      s_hi_q   <= csa_s[WIDTH-1:LO_W];
      cy_hi_q  <= csa_cy[WIDTH-1:LO_W-1];
    end
  end

  // ---------------- stage 2: upper halves + select ----------------
  logic [HI_W-1:0] sum_hi;
  logic [HI_W:0]   dif_hi;
  logic            hi_sum_cout;   // plain sum reached 2^WIDTH
  logic            hi_dif_cout;   // must never fire for reduced operands
  logic            sel_reduced;

  rca_seg #(.W(HI_W)) u_sum_hi (
    .a (x_hi_q), .b (y_hi_q), .cin (sum_c_q),
    .s (sum_hi), .cout (hi_sum_cout)
  );

  rca_seg #(.W(HI_W+1)) u_dif_hi (
    .a ({1'b0, s_hi_q}), .b (cy_hi_q), .cin (dif_c_q),
    .s (dif_hi), .cout (hi_dif_cout)
  );

  assign sel_reduced = dif_hi[HI_W];

  logic             out_v_q;
  logic [WIDTH-1:0] res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v_q <= 1'b0;
      res_q   <= '0;
    end else begin
      out_v_q <= v1_q;
      res_q   <= pick_result(sel_reduced, {sum_hi, sum_lo_q},
                             {dif_hi[HI_W-1:0], dif_lo_q});
    end
  end

  assign out_valid = out_v_q;
  assign out_res   = res_q;

  // ---------------- assertions ----------------
  // R2: valid input yields valid output two edges later
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  // R4: idle input yields idle output two edges later
  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);

  // R5: reduced operands give a result below the modulus
  p_below_mod_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ($past(in_x, 2) < $past(in_mod, 2))
               && ($past(in_y, 2) < $past(in_mod, 2)))
    |-> (out_res < $past(in_mod, 2)));

  // R7: overflow of the plain sum must force the reduced path
  p_ovf_reduces_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (v1_q && hi_sum_cout) |-> sel_reduced);

  // R1: extended reduced chain stays within WIDTH+1 bits
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    v1_q |-> !hi_dif_cout);
endmodule

// File: tb/pipe_mod_adder_tb.sv
module pipe_mod_adder_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_x = '0, in_y = '0, in_mod = 16'd2;
  logic         out_valid;
  logic [W-1:0] out_res;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pipe_mod_adder #(.WIDTH(W)) dut_i (
    .clk, .rst_n, .in_valid, .in_x, .in_y, .in_mod, .out_valid, .out_res
  );

  // independent reference: integer sum and conditional subtraction
  function automatic int ref_mod_add(int x, int y, int m);
    int t;
    t = x + y;
    while (t >= m) t = t - m;
    return t;
  endfunction

  // two-deep expected pipeline
  bit    e1_v = 0, e2_v = 0;
  int    e1_r, e2_r, e1_m, e2_m;
  string e1_t = "R4", e2_t = "R4";

  task automatic check_out();
    n_tests++;
    if (e2_v) begin
      if (out_valid !== 1'b1 || out_res !== e2_r[W-1:0]) begin
        n_fail++;
        $display("FAIL %s: valid=%0b res=%0h expected valid=1 res=%0h",
                 e2_t, out_valid, out_res, e2_r);
      end
      n_tests++;
      if (out_res >= e2_m[W-1:0]) begin  // R5
        n_fail++;
        $display("FAIL R5: res=%0h expected below %0h", out_res, e2_m);
      end
    end else if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R4: valid=%0b expected 0", out_valid);
    end
  endtask

  task automatic step(input bit v, input int x, input int y, input int m, input string tag);
    @(negedge clk);
    check_out();
    e2_v = e1_v; e2_r = e1_r; e2_m = e1_m; e2_t = e1_t;
    e1_v = v; e1_m = m; e1_t = tag;
    e1_r = v ? ref_mod_add(x, y, m) : 0;
    in_valid = v;
    in_x = x[W-1:0]; in_y = y[W-1:0]; in_mod = m[W-1:0];
  endtask

  initial begin
    int m, x, y;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_tests++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R4: reset valid=%0b expected 0", out_valid);
    end
    rst_n = 1'b1;

    // directed corners
    step(1, 0, 0, 7, "R1");
    step(1, 3, 4, 7, "R6");              // sum == modulus
    step(1, 16'hFFFE, 16'hFFFE, 16'hFFFF, "R7");  // sum overflows 2^16
    step(1, 16'h8000, 16'h8000, 16'h8001, "R7");
    step(1, 16'h00FF, 16'h0001, 16'h1000, "R8");  // low-half carry
    step(1, 16'h01FF, 16'h0001, 16'h0200, "R8");  // carry then reduce to 0
    step(0, 0, 0, 2, "R4");
    step(1, 1, 0, 2, "R1");
    step(0, 0, 0, 2, "R4");
    step(0, 0, 0, 2, "R4");
    // back-to-back with alternating moduli
    for (int i = 0; i < 8; i++)
      step(1, i * 37, i * 53, (i % 2) ? 16'hFFF1 : 16'h0400, "R3");

    // constrained random
    for (int i = 0; i < 2000; i++) begin
      m = 2 + int'($urandom % 32'hFFFE);
      x = int'($urandom % m);
      y = int'($urandom % m);
      step(($urandom % 5) != 0, x, y, m, "R1");
    end
    step(0, 0, 0, 2, "R2");
    step(0, 0, 0, 2, "R2");
    step(0, 0, 0, 2, "R4");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 50000);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule